// File: doc/BRIEF.md
# Six-Channel DMA Request Arbiter

This block decides, cycle by cycle, which of six DMA channels may move data next. Each channel raises a request line. The arbiter issues a registered one-hot grant to at most one requesting channel. The choice depends on a two-bit priority mode held in a 16-bit control register. That mode selects one of two fixed orderings or a rotating round-robin scheme that covers all six channels.

Grants are gated by several conditions. A software enable bit in the register and a master enable input must both be 1. Three status flags must all be 0: transfer end, address error and non-maskable interrupt. Hardware raises each flag through its own set input. Software can only clear a flag, by writing 0 to it. Clearing the enable bit withdraws any grant on the same clock edge that takes the write.

The register has one write port and a continuous read-back output. Address generation, transfer counting and bus timing belong to other blocks of the controller.

Top module: `dma_prio_arb`

## Requirements
- R1: After reset the register reads 0x0000, the grant is all zeros, and the round-robin search starts at channel 0.
- R2: The register layout is as follows. Bit 0 is the enable. Bit 1 is the transfer-end flag, bit 2 the address-error flag and bit 3 the NMI flag. Bits 9:8 hold the priority mode. Bits 15:10 and 7:4 always read 0, whatever value is written to them.
- R3: Writing 0 to a flag bit clears that flag. Writing 1 to a flag bit leaves the flag unchanged.
- R4: A pulse on a flag's set input raises that flag. If the set input and a write of 0 to that flag arrive in the same cycle, the set wins.
- R5: A grant is issued only when the enable bit is 1, the master enable input is 1 and all three flags are 0. In every other case the grant is all zeros.
- R6: The grant is registered and is recomputed on every edge. It is one-hot or zero, and it only ever names a channel that was requesting.
- R7: Mode 00 ranks the channels in the order 0, 1, 2, 3, 4, 5.
- R8: Mode 01 ranks the channels in the order 0, 2, 3, 1, 4, 5.
- R9: Mode 10 is treated exactly like mode 00.
- R10: Mode 11 is round-robin. The channel just granted drops to lowest priority, and the search resumes at the next index, wrapping from channel 5 to channel 0.
- R11: A register write that clears the enable bit, or a flag set, forces the grant to zero on the same edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write value |
| rd_data | output | 16 | Current register value |
| master_en | input | 1 | Master DMA enable |
| set_xfer_end | input | 1 | Hardware set of the transfer-end flag |
| set_addr_err | input | 1 | Hardware set of the address-error flag |
| set_nmi | input | 1 | Hardware set of the NMI flag |
| req | input | 6 | Channel request lines |
| grant | output | 6 | Registered one-hot grant |

## Verification
Every result is due one edge after its stimulus. This covers a register write, a flag set, a request pattern or an enable change. The grant is computed from the register's next value, so a write and a request pattern driven in the same cycle show their combined effect together on that edge. The bench drives its inputs at the falling edge. It samples `grant` and `rd_data` at the next falling edge, which places each check exactly one rising edge after its stimulus. The round-robin sequence is checked grant by grant on consecutive edges.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int REG_W    = 16;
    localparam int EN_BIT   = 0;
    localparam int TE_BIT   = 1;
    localparam int AE_BIT   = 2;
    localparam int NMI_BIT  = 3;
    localparam int MODE_LO  = 8;
    localparam int MODE_HI  = 9;

    typedef enum logic [1:0] {
        PM_FIXED_A = 2'b00,
        PM_FIXED_B = 2'b01,
        PM_RSVD    = 2'b10,
        PM_ROUND   = 2'b11
    } prio_mode_e;

    typedef struct packed {
        logic nmi;
        logic addr_err;
        logic xfer_end;
    } flags_t;

    typedef struct packed {
        prio_mode_e mode;
        flags_t     flags;
        logic       en;
    } opreg_t;

endpackage

// File: rtl/dma_arb_opreg.sv
module dma_arb_opreg
    import dma_arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             set_xfer_end,
    input  logic             set_addr_err,
    input  logic             set_nmi,
    output opreg_t           reg_q,
    output opreg_t           reg_d,
    output logic [REG_W-1:0] rd_data
);

    always_comb begin
        reg_d = reg_q;
        if (wr_en) begin
            reg_d.en             = wr_data[EN_BIT];
            reg_d.mode           = prio_mode_e'(wr_data[MODE_HI:MODE_LO]);
            reg_d.flags.xfer_end = reg_q.flags.xfer_end & wr_data[TE_BIT];
            reg_d.flags.addr_err = reg_q.flags.addr_err & wr_data[AE_BIT];
            reg_d.flags.nmi      = reg_q.flags.nmi      & wr_data[NMI_BIT];
        end
        if (set_xfer_end) reg_d.flags.xfer_end = 1'b1;
        if (set_addr_err) reg_d.flags.addr_err = 1'b1;
        if (set_nmi)      reg_d.flags.nmi      = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_q <= '0;
        else        reg_q <= reg_d;
    end

    always_comb begin
        rd_data                  = '0;
        rd_data[EN_BIT]          = reg_q.en;
        rd_data[TE_BIT]          = reg_q.flags.xfer_end;
        rd_data[AE_BIT]          = reg_q.flags.addr_err;
        rd_data[NMI_BIT]         = reg_q.flags.nmi;
        rd_data[MODE_HI:MODE_LO] = reg_q.mode;
    end

    // R3: a flag that is clear stays clear unless its set input fires
    a_r3_no_self_set: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q.flags == '0 && !set_xfer_end && !set_addr_err && !set_nmi)
        |=> (reg_q.flags == '0));

    // R4: a set input always wins, even against a same-cycle clear
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_nmi |=> reg_q.flags.nmi);

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
    import dma_arb_pkg::*;
#(
    parameter int NCH   = 6,
    localparam int PTR_W = $clog2(NCH)
) (
    input  logic [NCH-1:0]   req,
    input  prio_mode_e       mode,
    input  logic [PTR_W-1:0] ptr,
    output logic             found,
    output logic [PTR_W-1:0] idx
);

    logic [PTR_W-1:0] rank_ch [NCH];

    // Channel that sits at each rank for the selected mode
    for (genvar r = 0; r < NCH; r++) begin : g_rank
        always_comb begin
            int sum;
            sum = int'(ptr) + r;
            if (sum >= NCH) sum = sum - NCH;
            case (mode)
                PM_FIXED_B: begin
                    if      (r == 1) rank_ch[r] = PTR_W'(2);
                    else if (r == 2) rank_ch[r] = PTR_W'(3);
                    else if (r == 3) rank_ch[r] = PTR_W'(1);
                    else             rank_ch[r] = PTR_W'(r);
                end
                PM_ROUND: rank_ch[r] = PTR_W'(sum);
                default:  rank_ch[r] = PTR_W'(r);
            endcase
        end
    end

    // Lowest rank that is requesting wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int r = NCH - 1; r >= 0; r--) begin
            if (req[rank_ch[r]]) begin
                found = 1'b1;
                idx   = rank_ch[r];
            end
        end
    end

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
    import dma_arb_pkg::*;
#(
    parameter int NCH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [15:0]      wr_data,
    output logic [15:0]      rd_data,
    input  logic             master_en,
    input  logic             set_xfer_end,
    input  logic             set_addr_err,
    input  logic             set_nmi,
    input  logic [NCH-1:0]   req,
    output logic [NCH-1:0]   grant
);

    localparam int PTR_W = $clog2(NCH);

    typedef struct packed {
        logic [NCH-1:0]   grant;
        logic [PTR_W-1:0] ptr;
    } arb_t;

    opreg_t           reg_q;
    opreg_t           reg_d;
    logic             found;
    logic [PTR_W-1:0] idx;
    logic             go;
    arb_t             st_q;
    arb_t             st_d;

    dma_arb_opreg u_opreg (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .set_xfer_end (set_xfer_end),
        .set_addr_err (set_addr_err),
        .set_nmi      (set_nmi),
        .reg_q        (reg_q),
        .reg_d        (reg_d),
        .rd_data      (rd_data)
    );

    dma_arb_pick #(.NCH(NCH)) u_pick (
        .req   (req),
        .mode  (reg_d.mode),
        .ptr   (st_q.ptr),
        .found (found),
        .idx   (idx)
    );

    always_comb begin
        go         = reg_d.en & master_en & ~(|reg_d.flags);
        st_d       = st_q;
        st_d.grant = '0;
        if (go && found) begin
            st_d.grant[idx] = 1'b1;
            if (reg_d.mode == PM_ROUND) begin
                st_d.ptr = (int'(idx) == NCH - 1) ? '0 : idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign grant = st_q.grant;

    // R6: never more than one grant
    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: a grant names a channel that was requesting one edge earlier
    a_r6_req_backed: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (|(grant & $past(req))));

    // R5: a grant requires both enables and clear flags
    a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ($past(master_en) && reg_q.en && reg_q.flags == '0));

    // R11: a write clearing the enable bit leaves no grant
    a_r11_disable_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[0]) |=> (grant == '0));

endmodule

// File: tb/dma_prio_arb_test.sv
`timescale 1ns/1ps
module dma_prio_arb_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        master_en = 1'b0;
    logic        set_xfer_end = 1'b0;
    logic        set_addr_err = 1'b0;
    logic        set_nmi = 1'b0;
    logic [5:0]  req = '0;
    logic [5:0]  grant;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    dma_prio_arb uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .master_en    (master_en),
        .set_xfer_end (set_xfer_end),
        .set_addr_err (set_addr_err),
        .set_nmi      (set_nmi),
        .req          (req),
        .grant        (grant)
    );

    // {mode[1:0], req[5:0], expected grant[5:0]}
    localparam logic [13:0] VEC [12] = '{
        {2'b00, 6'b111111, 6'b000001},  // R7
        {2'b00, 6'b111110, 6'b000010},  // R7
        {2'b00, 6'b111100, 6'b000100},  // R7
        {2'b00, 6'b110000, 6'b010000},  // R7
        {2'b00, 6'b100000, 6'b100000},  // R7
        {2'b00, 6'b000000, 6'b000000},  // R6 request gone, grant gone
        {2'b01, 6'b111110, 6'b000100},  // R8 ch2 first after ch0
        {2'b01, 6'b001010, 6'b001000},  // R8 ch3 above ch1
        {2'b01, 6'b110010, 6'b000010},  // R8 ch1 above ch4
        {2'b01, 6'b110001, 6'b000001},  // R8
        {2'b10, 6'b001110, 6'b000010},  // R9 like mode 00
        {2'b10, 6'b110100, 6'b000100}   // R9
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at falling edge, let one rising edge pass, return at next falling edge
    task automatic cycle(input logic we, input logic [15:0] d, input logic [5:0] r);
        wr_en   = we;
        wr_data = d;
        req     = r;
        @(posedge clk);
        @(negedge clk);
        wr_en   = 1'b0;
        set_xfer_end = 1'b0;
        set_addr_err = 1'b0;
        set_nmi      = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0;
        req   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] exp_rr [9];
        do_reset();
        // R1 reset state
        check("R1 register", rd_data, 16'h0000);
        check("R1 grant", {10'd0, grant}, 16'h0000);

        master_en = 1'b1;
        // R2 R3: all-ones write, flags stay clear, reserved bits read 0
        cycle(1'b1, 16'hFFFF, 6'b000000);
        check("R2 layout", rd_data, 16'h0301);
        check("R3 write one no set", {13'd0, rd_data[3:1]}, 16'h0000);

        // R4 set beats a same-cycle clear
        set_xfer_end = 1'b1;
        cycle(1'b1, 16'h0000, 6'b000000);
        check("R4 set wins", rd_data, 16'h0002);
        cycle(1'b1, 16'hFFFF, 6'b000000);
        check("R3 one keeps flag", rd_data, 16'h0303);
        cycle(1'b1, 16'h0301, 6'b000000);
        check("R3 zero clears", rd_data, 16'h0301);

        // Fixed-mode table
        foreach (VEC[i]) begin
            logic [1:0] m;
            string      tag;
            m = VEC[i][13:12];
            if (VEC[i][11:6] == 6'b0) tag = "R6";
            else if (m == 2'b00)      tag = "R7";
            else if (m == 2'b01)      tag = "R8";
            else                      tag = "R9";
            cycle(1'b1, {6'd0, m, 8'h01}, VEC[i][11:6]);
            check(tag, {10'd0, grant}, {10'd0, VEC[i][5:0]});
        end

        // R5 gating by master enable and by flags
        master_en = 1'b0;
        cycle(1'b1, 16'h0001, 6'b000001);
        check("R5 master off", {10'd0, grant}, 16'h0000);
        master_en = 1'b1;
        cycle(1'b0, 16'h0000, 6'b000001);
        check("R5 both enables", {10'd0, grant}, 16'h0001);
        set_nmi = 1'b1;
        cycle(1'b0, 16'h0000, 6'b000001);
        check("R11 flag set drops grant", {10'd0, grant}, 16'h0000);
        check("R2 nmi bit", rd_data, 16'h0009);
        cycle(1'b1, 16'h0001, 6'b000001);
        check("R5 flag cleared", {10'd0, grant}, 16'h0001);
        cycle(1'b1, 16'h0000, 6'b000001);
        check("R11 enable cleared", {10'd0, grant}, 16'h0000);

        // R10 round-robin from a fresh reset
        do_reset();
        exp_rr = '{6'b000001, 6'b000010, 6'b000100, 6'b001000, 6'b010000,
                   6'b100000, 6'b000001, 6'b000100, 6'b000001};
        for (int k = 0; k < 9; k++) begin
            logic [5:0] r;
            r = (k < 7) ? 6'b111111 : 6'b000101;
            cycle(1'b1, 16'h0301, r);
            check("R10 rotation", {10'd0, grant}, {10'd0, exp_rr[k]});
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule